// File: doc/BRIEF.md
# Horizontal Drive Start-up Sequencer

This block drives the horizontal output stage of a deflection system when the main deflection controller cannot, and hands control to that controller once its pulses can be trusted. It runs from a free-running oscillator clock. After power-up, and whenever the main controller is not trusted, a local counter generates drive pulses with a fixed high time and a fixed period.

The block measures the period and the high time of every pulse arriving from the main controller. Once enough consecutive pulses fall inside their tolerance windows, the output switches to the main pulse train. The switch also requires that the main supply is good, that the protection flag is clear and that the driver-enable input is set. The switch is made at a main rising edge while the local pulse is low, so no shortened pulse reaches the driver. If the main supply drops, the block returns to the local pulses on the next clock. At that point it restarts a full local pulse, so the driver never sees a short pulse. While the line-retrace input is active, the output is held high in every mode.

Top module: `hdrv_startup`

## Requirements
- R1: While `por_n` is low, `drv_out` is low. After release, in standby, `drv_out` is high for HIGH clocks out of every PERIOD clocks, measured rising edge to rising edge (defaults 29 and 64).
- R2: While `ext_rst_n` is low, the block is in standby and keeps producing standby pulses of PERIOD/HIGH, even if it was following the main pulses before.
- R3: A main pulse counts as valid only when its rise-to-rise period lies in PERIOD±PER_TOL and its high time lies in HIGH±HI_TOL (defaults ±2 and ±2). A train with any other period or high time never causes a handover.
- R4: After REQ_GOOD consecutive valid periods (default 4) with `main_ok` high, `prot` low and `drv_en` high, the output follows `main_pls` with a delay of two clocks. The output then shows the main period and high time.
- R5: While `prot` is high or `drv_en` is low, no handover takes place, even for a valid main train.
- R6: A handover happens only at a main rising edge while the standby pulse is low. No output pulse shorter than HIGH is produced by the handover.
- R7: When `main_ok` falls while the main pulses are followed, `drv_out` is high in the next clock. A full standby pulse starts there, and the standby timing continues while the main pulses are ignored.
- R8: `retrace` high forces `drv_out` high in the same cycle, in every mode. When `retrace` is released, the selected source is shown again.
- R9: A train of REQ_GOOD pulses or fewer (fewer than REQ_GOOD measured periods) never causes a handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| ext_rst_n | input | 1 | Synchronous external reset, active low; the pulses continue during it |
| main_pls | input | 1 | Drive pulse train from the main controller |
| main_ok | input | 1 | Main supply valid |
| prot | input | 1 | Protection threshold exceeded |
| drv_en | input | 1 | Driver supply enable |
| retrace | input | 1 | Line retrace pulse |
| drv_out | output | 1 | Selected driver pulse |

## Verification
- **Main pulses:** they pass through one input register and one output register. A main edge therefore shows on `drv_out` two clocks after it is applied.
- **Standby pulses:** these come from the output register, one clock after the counter's next value is formed.
- **Fallback:** after a `main_ok` drop, the output is checked high at the very next falling clock edge.
- **Retrace:** its effect is combinational, so it is checked one nanosecond after it is driven.
- **Sampling:** a falling-edge monitor measures every high time and every rise-to-rise period of `drv_out`. Period and width checks are therefore taken only after whole pulses have completed.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  // true when val lies within centre +/- tol (inclusive)
  function automatic logic in_win(input logic [31:0] val, input logic [31:0] centre,
                                  input logic [31:0] tol);
    return (val + tol >= centre) && (val <= centre + tol);
  endfunction

  // number of counter bits needed to hold values 0..maxv
  function automatic int bits_for(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/hdrv_stby_gen.sv
module hdrv_stby_gen #(
  parameter int PERIOD = 64,
  parameter int HIGH   = 29,
  parameter int CW     = hdrv_pkg::bits_for(PERIOD - 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          restart,
  output logic [CW-1:0] cnt_q,
  output logic          hi_now,
  output logic          hi_next
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (restart)                          cnt_nxt = '0;
    else if (cnt_q == CW'(PERIOD - 1))    cnt_nxt = '0;
    else                                  cnt_nxt = cnt_q + 1'b1;
  end

  assign hi_now  = (cnt_q   < CW'(HIGH));
  assign hi_next = (cnt_nxt < CW'(HIGH));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= CW'(PERIOD - 1);
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/hdrv_pulse_qual.sv
module hdrv_pulse_qual #(
  parameter int PERIOD   = 64,
  parameter int HIGH     = 29,
  parameter int PER_TOL  = 2,
  parameter int HI_TOL   = 2,
  parameter int REQ_GOOD = 4,
  parameter int GW       = hdrv_pkg::bits_for(REQ_GOOD)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          main_pls,
  input  logic          gate_ok,
  output logic          m_lvl,
  output logic          take,
  output logic [GW-1:0] good_cnt
);
  import hdrv_pkg::*;
  localparam int PMAX = PERIOD + PER_TOL;
  localparam int MW   = bits_for(PMAX + 1);

  logic          m_s, m_d, hi_ok_q;
  logic [MW-1:0] per_cnt, hi_cnt;
  logic          rise, fall, per_ok, hi_ok, pulse_ok, timeout;

  assign rise     = m_s & ~m_d;
  assign fall     = ~m_s & m_d;
  assign per_ok   = in_win(32'(per_cnt), 32'(PERIOD), 32'(PER_TOL));
  assign hi_ok    = in_win(32'(hi_cnt),  32'(HIGH),   32'(HI_TOL));
  assign pulse_ok = rise & per_ok & hi_ok_q;
  assign timeout  = (per_cnt > MW'(PMAX));
  assign take     = pulse_ok & gate_ok & ((32'(good_cnt) + 32'd1) >= 32'(REQ_GOOD));
  assign m_lvl    = m_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_s      <= 1'b0;
      m_d      <= 1'b0;
      per_cnt  <= '1;
      hi_cnt   <= '0;
      hi_ok_q  <= 1'b0;
      good_cnt <= '0;
    end else begin
      m_s <= main_pls;
      m_d <= m_s;
      if (rise)                 per_cnt <= MW'(1);
      else if (per_cnt != '1)   per_cnt <= per_cnt + 1'b1;
      if (rise)                 hi_cnt <= MW'(1);
      else if (m_s && hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (fall)                 hi_ok_q <= hi_ok;
      if (!gate_ok)             good_cnt <= '0;
      else if (rise) begin
        if (!pulse_ok)                       good_cnt <= '0;
        else if (good_cnt != GW'(REQ_GOOD))  good_cnt <= good_cnt + 1'b1;
      end else if (timeout)     good_cnt <= '0;
    end
  end
endmodule

// File: rtl/hdrv_startup.sv
module hdrv_startup #(
  parameter int PERIOD   = 64,
  parameter int HIGH     = 29,
  parameter int PER_TOL  = 2,
  parameter int HI_TOL   = 2,
  parameter int REQ_GOOD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic main_pls,
  input  logic main_ok,
  input  logic prot,
  input  logic drv_en,
  input  logic retrace,
  output logic drv_out
);
  localparam int SCW = hdrv_pkg::bits_for(PERIOD - 1);
  localparam int GW  = hdrv_pkg::bits_for(REQ_GOOD);

  logic           gate_ok, m_lvl, take, restart;
  logic           sel_q, sel_nxt, src_q;
  logic           stby_hi, stby_hi_nxt;
  logic [SCW-1:0] stby_cnt;
  logic [GW-1:0]  good_cnt;

  assign gate_ok = main_ok & ~prot & drv_en & ext_rst_n;

  hdrv_pulse_qual #(
    .PERIOD(PERIOD), .HIGH(HIGH), .PER_TOL(PER_TOL),
    .HI_TOL(HI_TOL), .REQ_GOOD(REQ_GOOD), .GW(GW)
  ) qual_i (
    .clk(clk), .por_n(por_n), .main_pls(main_pls), .gate_ok(gate_ok),
    .m_lvl(m_lvl), .take(take), .good_cnt(good_cnt)
  );

  hdrv_stby_gen #(.PERIOD(PERIOD), .HIGH(HIGH), .CW(SCW)) stby_i (
    .clk(clk), .por_n(por_n), .restart(restart),
    .cnt_q(stby_cnt), .hi_now(stby_hi), .hi_next(stby_hi_nxt)
  );

  // source selection: leave at once on supply loss or reset,
  // enter only at a qualified main rise while the local pulse is low
  always_comb begin
    if (!main_ok || !ext_rst_n)         sel_nxt = 1'b0;
    else if (!sel_q && take && !stby_hi) sel_nxt = 1'b1;
    else                                 sel_nxt = sel_q;
  end

  assign restart = sel_q & ~sel_nxt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sel_q <= 1'b0;
      src_q <= 1'b0;
    end else begin
      sel_q <= sel_nxt;
      src_q <= sel_nxt ? m_lvl : stby_hi_nxt;
    end
  end

  assign drv_out = src_q | retrace;
endmodule

// File: rtl/hdrv_startup_chk.sv
module hdrv_startup_chk #(
  parameter int PERIOD   = 64,
  parameter int REQ_GOOD = 4,
  parameter int SCW      = hdrv_pkg::bits_for(PERIOD - 1),
  parameter int GW       = hdrv_pkg::bits_for(REQ_GOOD)
) (
  input logic           clk,
  input logic           por_n,
  input logic           ext_rst_n,
  input logic           main_ok,
  input logic           prot,
  input logic           drv_en,
  input logic           drv_out,
  input logic           sel_q,
  input logic           stby_hi,
  input logic [SCW-1:0] stby_cnt,
  input logic [GW-1:0]  good_cnt
);
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!por_n)
    32'(stby_cnt) < 32'(PERIOD));

  a_r2_ext_reset_standby: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |=> !sel_q);

  a_r4_gate_at_handover: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_q) |-> $past(main_ok && !prot && drv_en && ext_rst_n));

  a_r9_count_at_handover: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_q) |-> (32'($past(good_cnt)) + 32'd1 >= 32'(REQ_GOOD)));

  a_r6_standby_low_at_handover: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_q) |-> !$past(stby_hi));

  a_r7_leave_on_supply_loss: assert property (@(posedge clk) disable iff (!por_n)
    (sel_q && !main_ok) |=> !sel_q);

  a_r7_fallback_high: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sel_q) |-> drv_out);
endmodule

bind hdrv_startup hdrv_startup_chk #(.PERIOD(PERIOD), .REQ_GOOD(REQ_GOOD)) chk_i (
  .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .main_ok(main_ok),
  .prot(prot), .drv_en(drv_en), .drv_out(drv_out), .sel_q(sel_q),
  .stby_hi(stby_hi), .stby_cnt(stby_cnt), .good_cnt(good_cnt)
);

// File: tb/hdrv_startup_tb_top.sv
`timescale 1ns/1ps
module hdrv_startup_tb_top;
  localparam int P = 64;
  localparam int H = 29;
  localparam int R = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, main_pls = 1'b0, main_ok = 1'b0;
  logic prot = 1'b0, drv_en = 1'b1, retrace = 1'b0;
  logic drv_out;

  int checks = 0, errors = 0;
  int cyc = 0, rise_cyc = 0, last_hi = -1, last_per = -1, n_odd = 0, min_hi = 1000;
  bit prev = 1'b0, have_rise = 1'b0;

  always #10 clk = ~clk;

  hdrv_startup #(.PERIOD(P), .HIGH(H), .PER_TOL(2), .HI_TOL(2), .REQ_GOOD(R)) dut_i (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .main_pls(main_pls),
    .main_ok(main_ok), .prot(prot), .drv_en(drv_en), .retrace(retrace),
    .drv_out(drv_out)
  );

  // output pulse monitor
  always @(negedge clk) begin
    cyc++;
    if (drv_out && !prev) begin
      if (have_rise) last_per = cyc - rise_cyc;
      rise_cyc = cyc;
      have_rise = 1'b1;
    end
    if (!drv_out && prev && have_rise) begin
      last_hi = cyc - rise_cyc;
      if (last_hi < min_hi) min_hi = last_hi;
      if (last_hi != H) n_odd++;
    end
    prev = drv_out;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    #2;
    have_rise = 1'b0; n_odd = 0; min_hi = 1000; last_hi = -1; last_per = -1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_main(input int n, input int per, input int hi);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) main_pls = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk) main_pls = 1'b0;
      repeat (per - hi - 1) @(negedge clk);
    end
  endtask

  task automatic pulse_ext_reset();
    @(negedge clk) ext_rst_n = 1'b0;
    idle(3);
    ext_rst_n = 1'b1;
  endtask

  task automatic t_reset();
    idle(5);
    chk("R1 reset low", int'(drv_out), 0);
    por_n = 1'b1;
    clr_mon();
    idle(4 * P);
    chk("R1 standby period", last_per, P);
    chk("R1 standby high", last_hi, H);
  endtask

  task automatic t_short_train();
    main_ok = 1'b1;
    clr_mon();
    send_main(R, 65, 30);
    idle(3 * P);
    chk("R9 short train no handover", n_odd, 0);
    pulse_ext_reset();
  endtask

  task automatic t_out_of_window();
    clr_mon();
    send_main(45, 70, 30);
    chk("R3 period out of window", n_odd, 0);
    clr_mon();
    send_main(45, 65, 33);
    chk("R3 high time out of window", n_odd, 0);
    pulse_ext_reset();
  endtask

  task automatic t_blocked();
    prot = 1'b1;
    clr_mon();
    send_main(45, 65, 30);
    chk("R5 protection blocks", n_odd, 0);
    prot = 1'b0;
    drv_en = 1'b0;
    clr_mon();
    send_main(45, 65, 30);
    chk("R5 driver enable blocks", n_odd, 0);
    drv_en = 1'b1;
    pulse_ext_reset();
  endtask

  task automatic t_handover();
    clr_mon();
    send_main(45, 65, 30);
    chk("R4 follows main high", last_hi, 30);
    chk("R4 follows main period", last_per, 65);
    chk("R6 no runt at handover", int'(min_hi >= H), 1);
  endtask

  task automatic t_ext_reset();
    @(negedge clk) ext_rst_n = 1'b0;
    clr_mon();
    send_main(10, 65, 30);
    chk("R2 standby period in reset", last_per, P);
    chk("R2 standby high in reset", last_hi, H);
    ext_rst_n = 1'b1;
  endtask

  task automatic t_fallback();
    send_main(45, 65, 30);
    chk("R4 main mode again", last_hi, 30);
    idle(2);
    @(negedge clk) main_ok = 1'b0;
    @(negedge clk);
    chk("R7 high next cycle", int'(drv_out), 1);
    clr_mon();
    send_main(10, 65, 30);
    chk("R7 standby period", last_per, P);
    chk("R7 standby high", last_hi, H);
    chk("R7 main ignored", n_odd, 0);
  endtask

  task automatic t_retrace();
    @(negedge clk);
    while (!drv_out) @(negedge clk);
    while (drv_out) @(negedge clk);
    idle(3);
    retrace = 1'b1;
    #1;
    chk("R8 retrace same cycle", int'(drv_out), 1);
    @(negedge clk);
    chk("R8 retrace held", int'(drv_out), 1);
    retrace = 1'b0;
    #1;
    chk("R8 retrace released", int'(drv_out), 0);
  endtask

  initial begin
    t_reset();
    t_short_train();
    t_out_of_window();
    t_blocked();
    t_handover();
    t_ext_reset();
    t_fallback();
    t_retrace();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule